// File: doc/BRIEF.md
# Load-Use and Branch Stall Accounting Unit

This block watches the instruction stream of an in-order core and keeps a record of the pipeline bubbles that the core would suffer. It does not forward data or freeze the pipeline. It only raises a hazard flag and keeps running totals. Each retired instruction is presented for one cycle with `insn_valid`. The instruction may carry up to two source register numbers, an optional load destination and a branch indication with its outcome.

A register written by a load is first recorded in a pending mask. A separate `boundary` strobe moves the pending mask into the active mask and empties the pending mask. So a load penalises only the instruction that follows the next boundary. Every source that hits the active mask costs a fixed penalty of two cycles. Every taken branch also costs two cycles. Load stalls, branch stalls, taken branches and untaken branches each have their own saturating counter.

Top module: `stall_acct`

## Requirements
- R1: A synchronous reset clears all four counters and both register masks, so `hazard` stays low and every counter reads 0 after reset.
- R2: For an instruction with `insn_valid` high, each valid source whose register number is set in the active mask adds 2 to `load_stall_cnt`. Two matching sources add 4, including when both sources name the same register.
- R3: A source with its valid bit low never adds a stall and never raises `hazard`, even if its register number is set in the active mask.
- R4: A load (`insn_valid` and `ld_valid`) sets bit `ld_reg` of the pending mask only. The bit reaches the active mask at the next cycle with `boundary` high, which may be the load's own cycle. An instruction in the same cycle as the load, or before that boundary, does not see the bit.
- R5: On `boundary`, the active mask is replaced by the pending mask, and the pending mask is cleared. A loaded register therefore stalls only the instructions between that boundary and the following one.
- R6: An instruction with `br_valid` and `br_taken` high adds 2 to `branch_stall_cnt` and 1 to `taken_cnt`. The sources of a branch are checked like any other sources.
- R7: An instruction with `br_valid` high and `br_taken` low adds 1 to `untaken_cnt` and leaves `branch_stall_cnt` and `taken_cnt` unchanged.
- R8: Each counter is `CNT_W` bits wide (32 by default). When an addition would pass the all-ones value, the counter holds at all-ones.
- R9: `hazard` is combinational. It is high in the same cycle as an instruction that adds any load stall or branch stall, and low otherwise.
- R10: With `insn_valid` low, the source, load and branch inputs are ignored. No counter changes, no mask bit is set and `hazard` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insn_valid | input | 1 | A retired instruction is presented this cycle |
| boundary | input | 1 | Instruction boundary: pending mask moves to active mask |
| src0_valid | input | 1 | First source names a register |
| src0_reg | input | RW (4) | First source register number |
| src1_valid | input | 1 | Second source names a register |
| src1_reg | input | RW (4) | Second source register number |
| ld_valid | input | 1 | Instruction is a load with a destination register |
| ld_reg | input | RW (4) | Load destination register number |
| br_valid | input | 1 | Instruction is a branch |
| br_taken | input | 1 | Branch outcome is taken |
| hazard | output | 1 | A stall is charged for the current instruction |
| load_stall_cnt | output | CNT_W (32) | Accumulated load-use stall cycles |
| branch_stall_cnt | output | CNT_W (32) | Accumulated taken-branch stall cycles |
| taken_cnt | output | CNT_W (32) | Number of taken branches |
| untaken_cnt | output | CNT_W (32) | Number of untaken branches |

## Verification
The masks cannot be read directly. Any error in them shows up through `hazard` in the same cycle as the first affected instruction, and in `load_stall_cnt` one clock later. A stale pending bit or a missed clear therefore shows within two instructions of the faulty boundary. Counter faults, such as a wrong increment, a missed saturation or a wrap to zero, appear on the counter output one edge after the instruction that caused them. A second instance with narrow counters drives saturation to its limit well within the run.

// File: rtl/stall_acct.sv
module stall_acct #(
  parameter int NREG    = 16,
  parameter int CNT_W   = 32,
  parameter int PENALTY = 2,
  localparam int RW     = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             insn_valid,
  input  logic             boundary,
  input  logic             src0_valid,
  input  logic [RW-1:0]    src0_reg,
  input  logic             src1_valid,
  input  logic [RW-1:0]    src1_reg,
  input  logic             ld_valid,
  input  logic [RW-1:0]    ld_reg,
  input  logic             br_valid,
  input  logic             br_taken,
  output logic             hazard,
  output logic [CNT_W-1:0] load_stall_cnt,
  output logic [CNT_W-1:0] branch_stall_cnt,
  output logic [CNT_W-1:0] taken_cnt,
  output logic [CNT_W-1:0] untaken_cnt
);
  localparam logic [CNT_W-1:0] PEN = CNT_W'(PENALTY);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [NREG-1:0] act_mask, pend_mask, ld_bit;
  logic [CNT_W-1:0] ld_inc;
  logic hit0, hit1, take, skip;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CNT_W] ? TOP : s[CNT_W-1:0];
  endfunction

  assign hit0   = insn_valid && src0_valid && act_mask[src0_reg];
  assign hit1   = insn_valid && src1_valid && act_mask[src1_reg];
  assign take   = insn_valid && br_valid && br_taken;
  assign skip   = insn_valid && br_valid && !br_taken;
  assign ld_inc = (hit0 ? PEN : '0) + (hit1 ? PEN : '0);
  assign hazard = hit0 || hit1 || take;

  always_comb begin
    ld_bit = '0;
    if (insn_valid && ld_valid) ld_bit[ld_reg] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_mask  <= '0;
      pend_mask <= '0;
    end else if (boundary) begin
      act_mask  <= pend_mask | ld_bit;
      pend_mask <= '0;
    end else begin
      pend_mask <= pend_mask | ld_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_stall_cnt   <= '0;
      branch_stall_cnt <= '0;
      taken_cnt        <= '0;
      untaken_cnt      <= '0;
    end else begin
      load_stall_cnt <= sat_add(load_stall_cnt, ld_inc);
      if (take) begin
        branch_stall_cnt <= sat_add(branch_stall_cnt, PEN);
        taken_cnt        <= sat_add(taken_cnt, ONE);
      end
      if (skip) untaken_cnt <= sat_add(untaken_cnt, ONE);
    end
  end

  a_r10_idle_no_count: assert property (@(posedge clk) disable iff (rst)
    !insn_valid |=> $stable(load_stall_cnt) && $stable(branch_stall_cnt)
                    && $stable(taken_cnt) && $stable(untaken_cnt));

  a_r9_hazard_needs_insn: assert property (@(posedge clk) disable iff (rst)
    hazard |-> insn_valid);

  a_r7_untaken_no_stall: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && br_valid && !br_taken) |=> $stable(branch_stall_cnt) && $stable(taken_cnt));

  a_r6_taken_counts: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && br_valid && br_taken && taken_cnt != TOP) |=> taken_cnt != $past(taken_cnt));

  a_r8_sat_hold: assert property (@(posedge clk) disable iff (rst)
    (load_stall_cnt == TOP) |=> load_stall_cnt == TOP);

  a_r3_invalid_src_quiet: assert property (@(posedge clk) disable iff (rst)
    (!src0_valid && !src1_valid) |=> $stable(load_stall_cnt));
endmodule

// File: tb/stall_acct_bench.sv
module stall_acct_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic insn_valid = 0, boundary = 0, src0_valid = 0, src1_valid = 0;
  logic ld_valid = 0, br_valid = 0, br_taken = 0;
  logic [3:0] src0_reg = 0, src1_reg = 0, ld_reg = 0;
  logic hazard, hazard_s;
  logic [31:0] ld_cnt, br_cnt, tk_cnt, un_cnt;
  logic [3:0] ld_s, br_s, tk_s, un_s;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  stall_acct u_stall_acct (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .boundary(boundary),
    .src0_valid(src0_valid), .src0_reg(src0_reg), .src1_valid(src1_valid), .src1_reg(src1_reg),
    .ld_valid(ld_valid), .ld_reg(ld_reg), .br_valid(br_valid), .br_taken(br_taken),
    .hazard(hazard), .load_stall_cnt(ld_cnt), .branch_stall_cnt(br_cnt),
    .taken_cnt(tk_cnt), .untaken_cnt(un_cnt));

  stall_acct #(.CNT_W(4)) u_sat (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .boundary(boundary),
    .src0_valid(src0_valid), .src0_reg(src0_reg), .src1_valid(src1_valid), .src1_reg(src1_reg),
    .ld_valid(ld_valid), .ld_reg(ld_reg), .br_valid(br_valid), .br_taken(br_taken),
    .hazard(hazard_s), .load_stall_cnt(ld_s), .branch_stall_cnt(br_s),
    .taken_cnt(tk_s), .untaken_cnt(un_s));

  logic [15:0] m_act = 0, m_pend = 0;
  longint m_ld = 0, m_br = 0, m_tk = 0, m_un = 0;
  longint s_ld = 0, s_br = 0, s_tk = 0, s_un = 0;
  localparam longint BIG = 64'hFFFF_FFFF;

  function automatic longint sat(longint a, longint inc, longint mx);
    return (a + inc > mx) ? mx : a + inc;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic iv, input logic bd,
                      input logic s0v, input logic [3:0] s0,
                      input logic s1v, input logic [3:0] s1,
                      input logic lv, input logic [3:0] lr,
                      input logic bv, input logic bt, input string tag);
    longint inc;
    logic h0, h1, tk, exp_h;
    logic [15:0] lb;
    @(negedge clk);
    insn_valid = iv; boundary = bd; src0_valid = s0v; src0_reg = s0;
    src1_valid = s1v; src1_reg = s1; ld_valid = lv; ld_reg = lr;
    br_valid = bv; br_taken = bt;
    h0 = iv && s0v && m_act[s0];
    h1 = iv && s1v && m_act[s1];
    tk = iv && bv && bt;
    exp_h = h0 || h1 || tk;
    #8;
    check({tag, " R9 hazard"}, longint'(hazard), longint'(exp_h));
    check({tag, " R9 hazard narrow"}, longint'(hazard_s), longint'(exp_h));
    @(posedge clk);
    inc = (h0 ? 2 : 0) + (h1 ? 2 : 0);
    lb = (iv && lv) ? (16'd1 << lr) : 16'd0;
    m_ld = sat(m_ld, inc, BIG); s_ld = sat(s_ld, inc, 15);
    if (tk) begin
      m_br = sat(m_br, 2, BIG); s_br = sat(s_br, 2, 15);
      m_tk = sat(m_tk, 1, BIG); s_tk = sat(s_tk, 1, 15);
    end
    if (iv && bv && !bt) begin
      m_un = sat(m_un, 1, BIG); s_un = sat(s_un, 1, 15);
    end
    if (bd) begin m_act = m_pend | lb; m_pend = 0; end
    else m_pend = m_pend | lb;
    #2;
    check({tag, " R2 load stall"}, longint'(ld_cnt), m_ld);
    check({tag, " R6 branch stall"}, longint'(br_cnt), m_br);
    check({tag, " R6 taken"}, longint'(tk_cnt), m_tk);
    check({tag, " R7 untaken"}, longint'(un_cnt), m_un);
    check({tag, " R8 sat load"}, longint'(ld_s), s_ld);
    check({tag, " R8 sat branch"}, longint'(br_s), s_br);
    check({tag, " R8 sat taken"}, longint'(tk_s), s_tk);
    check({tag, " R8 sat untaken"}, longint'(un_s), s_un);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check("R1 reset load", longint'(ld_cnt), 0);
    check("R1 reset branch", longint'(br_cnt), 0);
    check("R1 reset taken", longint'(tk_cnt), 0);
    check("R1 reset untaken", longint'(un_cnt), 0);
    step(1,1, 1,4'd3, 1,4'd7, 0,0, 0,0, "R1 empty mask");
    // R2 single and double hits
    step(1,1, 0,0, 0,0, 1,4'd3, 0,0, "R2 load r3");
    step(1,1, 1,4'd3, 0,0, 0,0, 0,0, "R2 use r3");
    step(1,1, 0,0, 0,0, 1,4'd5, 0,0, "R2 load r5");
    step(1,1, 1,4'd5, 1,4'd5, 1,4'd6, 0,0, "R2 double r5");
    // R5 r5 no longer active, r6 is
    step(1,1, 1,4'd5, 1,4'd6, 0,0, 0,0, "R5 expire");
    // R3 invalid sources naming a loaded register
    step(1,1, 0,0, 0,0, 1,4'd9, 0,0, "R3 load r9");
    step(1,1, 0,4'd9, 0,4'd9, 0,0, 0,0, "R3 invalid src");
    // R4 load without boundary stays pending
    step(1,0, 0,0, 0,0, 1,4'd2, 0,0, "R4 load r2 pending");
    step(1,1, 1,4'd2, 0,0, 0,0, 0,0, "R4 not yet active");
    step(1,1, 1,4'd2, 0,0, 0,0, 0,0, "R4 now active");
    // R10 idle cycle ignores everything
    step(1,1, 0,0, 0,0, 1,4'd1, 0,0, "R10 load r1");
    step(0,0, 1,4'd1, 1,4'd1, 1,4'd4, 1,1, "R10 idle");
    step(1,1, 1,4'd1, 0,0, 0,0, 0,0, "R10 r1 still active");
    step(1,1, 1,4'd4, 0,0, 0,0, 0,0, "R10 r4 never loaded");
    // R6 R7 branches
    step(1,1, 0,0, 0,0, 1,4'd8, 0,0, "R6 load r8");
    step(1,1, 1,4'd8, 0,0, 0,0, 1,1, "R6 taken with hit");
    step(1,1, 0,0, 0,0, 0,0, 1,0, "R7 untaken");
    repeat (3000) begin
      logic iv, bd;
      iv = ($urandom % 8) != 0;
      bd = ($urandom % 5) != 0;
      step(iv, bd, $urandom % 2 == 0, 4'($urandom % 6), $urandom % 2 == 0, 4'($urandom % 6),
           $urandom % 2 == 0, 4'($urandom % 6), $urandom % 3 == 0, $urandom % 2 == 0, "rand");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule